// File: doc/BRIEF.md
# Packed-Lane Vector Immediate ALU

This unit executes one instruction from the immediate-form integer arithmetic group on a 128-bit vector. A 32-bit instruction word and a source vector arrive together with `in_valid`. The word picks the lane width (8, 16, 32 or 64 bits), the operation and an 8-bit immediate. The unit widens that immediate to a scalar and applies it to every lane at once. It returns the destination vector one clock later with `out_valid`. The operations are add, subtract, reverse subtract, signed and unsigned saturating add and subtract, signed and unsigned min and max, and multiply.

Words outside the accepted encodings are not executed. They come back in the same result slot with `out_illegal` raised, and the source vector passes through unchanged. A small state machine sequences the result slot. Its states are `ST_IDLE` (no result), `ST_RESULT` (a good result is presented) and `ST_TRAP` (a rejected word is reported). From any state, a cycle with `in_valid` low goes to `ST_IDLE`. A cycle with `in_valid` high and an accepted word goes to `ST_RESULT`. A cycle with `in_valid` high and a rejected word goes to `ST_TRAP`. Reset forces `ST_IDLE`.

Top module: `lane_imm_alu`

## Requirements
- R1: A word is accepted only when bits 31:24 are 8'b00100101. Any other head byte raises `out_illegal`.
- R2: Bits 23:22 pick the lane width (00=8, 01=16, 10=32, 11=64 bits). Each lane is computed alone, with no carry or borrow between lanes.
- R3: Sub-group 3'b100 in bits 21:19 is add/subtract, and bits 15:14 must be 2'b11. The immediate is the unsigned value in bits 12:5, shifted left by 8 when bit 13 is set, then truncated to the lane width. Code 000 in bits 18:16 adds, 001 subtracts (by adding the negated immediate) and 011 computes immediate minus lane. All three wrap modulo the lane width.
- R4: In the same sub-group, code 100 is signed saturating add, 101 unsigned saturating add, 110 signed saturating subtract and 111 unsigned saturating subtract. The immediate counts as a non-negative number in all four. Signed results clamp to the lane's most positive or most negative value. Unsigned results clamp to all-ones on overflow and to zero on underflow.
- R5: In the add/subtract sub-group, the word is rejected for code 010, for bits 15:14 not equal to 11, and for 8-bit lanes with bit 13 set.
- R6: Sub-group 3'b101 is min/max and needs bits 15:13 equal to 110. Code 000 is signed max, 001 unsigned max, 010 signed min and 011 unsigned min. The immediate is sign-extended for the signed forms and zero-extended for the unsigned forms. Codes 1xx are rejected.
- R7: Sub-group 3'b110 with code 000 and bits 15:13 equal to 110 multiplies each lane by the sign-extended immediate and keeps the low lane-width bits. Any other code in that sub-group is rejected, and so is any other sub-group.
- R8: A rejected word raises `out_illegal` together with `out_valid` for one cycle. `dst_vec` then equals the source vector unchanged.
- R9: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `dst_reg` carries bits 4:0 of that word.
- R10: With `in_valid` low, `out_valid` and `out_illegal` stay low and `dst_vec` holds its last value.
- R11: Active-low synchronous reset clears `out_valid`, `out_illegal`, `dst_vec` and `dst_reg`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word and source vector are present |
| instr | input | 32 | Instruction word |
| src_vec | input | 128 | Source vector (also the destination register's old value) |
| out_valid | output | 1 | Result slot holds a response |
| out_illegal | output | 1 | Response is for a rejected word |
| dst_reg | output | 5 | Destination register number from the word |
| dst_vec | output | 128 | Destination vector |

## Verification
Clocked properties check the handshake timing on every cycle. They confirm that a response follows each valid cycle and that no response appears otherwise. They also check that a reject is always paired with valid, that a rejected word returns the source unchanged, that a bad head byte and a shifted byte-lane immediate are always rejected, and that the result holds while idle. The arithmetic itself is shown only by the bench scenarios. These compare every lane against an independent model across all four lane widths and every operation code, including saturation edges, wrap-around, reverse subtraction, shifted immediates in 16-bit lanes, and each rejected encoding.

// File: rtl/lia_pkg.sv
package lia_pkg;

    typedef enum logic [3:0] {
        OP_ADD,
        OP_SUBR,
        OP_SQADD,
        OP_UQADD,
        OP_SQSUB,
        OP_UQSUB,
        OP_SMAX,
        OP_UMAX,
        OP_SMIN,
        OP_UMIN,
        OP_MUL
    } lia_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RESULT,
        ST_TRAP
    } lia_state_e;

    localparam logic [7:0] HEAD_BYTE = 8'b0010_0101;
    localparam logic [2:0] GRP_ADDSUB = 3'b100;
    localparam logic [2:0] GRP_MINMAX = 3'b101;
    localparam logic [2:0] GRP_MUL    = 3'b110;
    localparam int         IMM_W      = 64;

endpackage

// File: rtl/lia_decode.sv
module lia_decode
    import lia_pkg::*;
(
    input  logic [31:0]      instr,
    output lia_op_e          op,
    output logic [1:0]       esz,
    output logic [IMM_W-1:0] imm,
    output logic [4:0]       rd,
    output logic             bad
);

    logic [2:0]       grp;
    logic [2:0]       code;
    logic [2:0]       mid;
    logic [7:0]       raw;
    logic             shift8;
    logic [IMM_W-1:0] zext_imm;
    logic [IMM_W-1:0] sext_imm;
    logic [IMM_W-1:0] shifted_imm;

    always_comb begin
        grp         = instr[21:19];
        code        = instr[18:16];
        mid         = instr[15:13];
        raw         = instr[12:5];
        shift8      = instr[13];
        esz         = instr[23:22];
        rd          = instr[4:0];
        zext_imm    = {{(IMM_W-8){1'b0}}, raw};
        sext_imm    = {{(IMM_W-8){raw[7]}}, raw};
        shifted_imm = shift8 ? (zext_imm << 8) : zext_imm;
    end

    always_comb begin
        op  = OP_ADD;
        imm = '0;
        bad = 1'b0;
        if (instr[31:24] != HEAD_BYTE) begin
            bad = 1'b1;
        end else begin
            unique case (grp)
                GRP_ADDSUB: begin
                    imm = shifted_imm;
                    if (mid[2:1] != 2'b11)            bad = 1'b1;
                    if ((esz == 2'b00) && shift8)     bad = 1'b1;
                    unique case (code)
                        3'b000: op = OP_ADD;
                        3'b001: begin
                            op  = OP_ADD;
                            imm = -shifted_imm;
                        end
                        3'b011: op = OP_SUBR;
                        3'b100: op = OP_SQADD;
                        3'b101: op = OP_UQADD;
                        3'b110: op = OP_SQSUB;
                        3'b111: op = OP_UQSUB;
                        default: bad = 1'b1;
                    endcase
                end
                GRP_MINMAX: begin
                    if (mid != 3'b110) bad = 1'b1;
                    unique case (code)
                        3'b000: begin op = OP_SMAX; imm = sext_imm; end
                        3'b001: begin op = OP_UMAX; imm = zext_imm; end
                        3'b010: begin op = OP_SMIN; imm = sext_imm; end
                        3'b011: begin op = OP_UMIN; imm = zext_imm; end
                        default: bad = 1'b1;
                    endcase
                end
                GRP_MUL: begin
                    op  = OP_MUL;
                    imm = sext_imm;
                    if ((mid != 3'b110) || (code != 3'b000)) bad = 1'b1;
                end
                default: bad = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/lia_lane.sv
module lia_lane
    import lia_pkg::*;
#(
    parameter int W = 8
) (
    input  lia_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

    logic signed [W+1:0] a_sx;
    logic signed [W+1:0] b_zx;
    logic signed [W+1:0] s_sum;
    logic signed [W+1:0] s_dif;
    logic        [W:0]   u_sum;
    logic        [W-1:0] mul_lo;
    logic                s_gt;
    logic                u_gt;

    function automatic logic [W-1:0] clamp_s(input logic [W+1:0] r);
        if (!r[W+1] && (r[W] || r[W-1]))
            return S_MAX;
        else if (r[W+1] && !(r[W] && r[W-1]))
            return S_MIN;
        else
            return r[W-1:0];
    endfunction

    always_comb begin
        a_sx   = {{2{a[W-1]}}, a};
        b_zx   = {2'b00, b};
        s_sum  = a_sx + b_zx;
        s_dif  = a_sx - b_zx;
        u_sum  = {1'b0, a} + {1'b0, b};
        mul_lo = a * b;
        s_gt   = $signed(a) > $signed(b);
        u_gt   = a > b;
    end

    always_comb begin
        unique case (op)
            OP_ADD:   y = a + b;
            OP_SUBR:  y = b - a;
            OP_SQADD: y = clamp_s(s_sum);
            OP_SQSUB: y = clamp_s(s_dif);
            OP_UQADD: y = u_sum[W] ? {W{1'b1}} : u_sum[W-1:0];
            OP_UQSUB: y = (a < b) ? '0 : (a - b);
            OP_SMAX:  y = s_gt ? a : b;
            OP_SMIN:  y = s_gt ? b : a;
            OP_UMAX:  y = u_gt ? a : b;
            OP_UMIN:  y = u_gt ? b : a;
            OP_MUL:   y = mul_lo;
            default:  y = a;
        endcase
    end

endmodule

// File: rtl/lane_imm_alu.sv
module lane_imm_alu
    import lia_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      instr,
    input  logic [VEC_W-1:0] src_vec,
    output logic             out_valid,
    output logic             out_illegal,
    output logic [4:0]       dst_reg,
    output logic [VEC_W-1:0] dst_vec
);

    localparam int N_SIZES = 4;

    lia_op_e          dec_op;
    logic [1:0]       dec_esz;
    logic [IMM_W-1:0] dec_imm;
    logic [4:0]       dec_rd;
    logic             dec_bad;

    lia_decode u_decode (
        .instr (instr),
        .op    (dec_op),
        .esz   (dec_esz),
        .imm   (dec_imm),
        .rd    (dec_rd),
        .bad   (dec_bad)
    );

    logic [VEC_W-1:0] res_by_size [N_SIZES];

    for (genvar s = 0; s < N_SIZES; s++) begin : g_size
        localparam int LW = 8 << s;
        localparam int NL = VEC_W / LW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            lia_lane #(.W(LW)) u_lane (
                .op (dec_op),
                .a  (src_vec[l*LW +: LW]),
                .b  (dec_imm[LW-1:0]),
                .y  (res_by_size[s][l*LW +: LW])
            );
        end
    end

    logic [VEC_W-1:0] res_sel;
    always_comb res_sel = res_by_size[dec_esz];

    lia_state_e state_q, state_d;

    always_comb begin
        state_d = ST_IDLE;
        if (in_valid)
            state_d = dec_bad ? ST_TRAP : ST_RESULT;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:   begin out_valid = 1'b0; out_illegal = 1'b0; end
            ST_RESULT: begin out_valid = 1'b1; out_illegal = 1'b0; end
            ST_TRAP:   begin out_valid = 1'b1; out_illegal = 1'b1; end
            default:   begin out_valid = 1'b0; out_illegal = 1'b0; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_vec <= '0;
            dst_reg <= '0;
        end else if (in_valid) begin
            dst_vec <= dec_bad ? src_vec : res_sel;
            dst_reg <= dec_rd;
        end
    end

    // R9
    resp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(dst_vec)));

    // R8
    reject_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> out_valid);

    // R8
    reject_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_bad) |=> (dst_vec == $past(src_vec)));

    // R1
    head_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:24] != HEAD_BYTE) |=> out_illegal);

    // R5
    byte_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[23:22] == 2'b00 && instr[21:19] == GRP_ADDSUB && instr[13])
        |=> out_illegal);

endmodule

// File: tb/lane_imm_alu_tb.sv
`timescale 1ns/1ps
module lane_imm_alu_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic [127:0] src_vec = '0;
    logic         out_valid;
    logic         out_illegal;
    logic [4:0]   dst_reg;
    logic [127:0] dst_vec;

    always #2.5 clk = ~clk;

    lane_imm_alu u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .src_vec(src_vec), .out_valid(out_valid), .out_illegal(out_illegal),
        .dst_reg(dst_reg), .dst_vec(dst_vec)
    );

    typedef struct {
        bit           ill;
        logic [4:0]   rd;
        logic [127:0] vec;
        string        tag;
    } exp_t;

    exp_t         sb_q[$];
    int           n_chk = 0;
    int           n_bad = 0;
    logic [127:0] last_vec = '0;
    bit           done = 0;

    function automatic logic [31:0] mk(input logic [2:0] g, input logic [2:0] c,
                                       input logic [1:0] esz, input logic [2:0] mid,
                                       input logic [7:0] im, input logic [4:0] rd);
        return {8'b0010_0101, esz, g, c, mid, im, rd};
    endfunction

    function automatic logic [63:0] lane_op(input logic [2:0] g, input logic [2:0] c,
                                            input logic [63:0] a, input logic [63:0] b,
                                            input int w, input logic [63:0] m);
        logic signed [66:0] sa, sb_s, sb_z, t, hi, lo;
        logic [66:0] u;
        sa   = a[w-1] ? {3'b111, a | ~m} : {3'b000, a};
        sb_s = b[w-1] ? {3'b111, b | ~m} : {3'b000, b};
        sb_z = {3'b000, b};
        hi   = {3'b000, m >> 1};
        lo   = -hi - 1;
        if (g == 3'b110) return a * b;
        if (g == 3'b101) begin
            case (c)
                3'b000: return (sa > sb_s) ? a : b;
                3'b001: return (a > b) ? a : b;
                3'b010: return (sa < sb_s) ? a : b;
                default: return (a < b) ? a : b;
            endcase
        end
        case (c)
            3'b000: return a + b;
            3'b001: return a - b;
            3'b011: return b - a;
            3'b100, 3'b110: begin
                t = (c == 3'b100) ? sa + sb_z : sa - sb_z;
                if (t > hi) t = hi;
                if (t < lo) t = lo;
                return t[63:0];
            end
            3'b101: begin
                u = {3'b000, a} + {3'b000, b};
                return (u > {3'b000, m}) ? m : u[63:0];
            end
            default: return (a < b) ? 64'd0 : a - b;
        endcase
    endfunction

    function automatic void model(input logic [31:0] wd, input logic [127:0] src,
                                  output bit ill, output logic [127:0] y);
        int w;
        logic [63:0] m, im, a, r;
        logic [2:0] g, c;
        ill = 0;
        w   = 8 << wd[23:22];
        m   = (w == 64) ? '1 : ((64'd1 << w) - 1);
        g   = wd[21:19];
        c   = wd[18:16];
        im  = '0;
        if (wd[31:24] != 8'b0010_0101) ill = 1;
        else if (g == 3'b100) begin
            if (wd[15:14] != 2'b11 || c == 3'b010 || (w == 8 && wd[13])) ill = 1;
            im = {56'd0, wd[12:5]} << (wd[13] ? 8 : 0);
        end else if (g == 3'b101) begin
            if (wd[15:13] != 3'b110 || c[2]) ill = 1;
            im = c[0] ? {56'd0, wd[12:5]} : {{56{wd[12]}}, wd[12:5]};
        end else if (g == 3'b110) begin
            if (c != 3'b000 || wd[15:13] != 3'b110) ill = 1;
            im = {{56{wd[12]}}, wd[12:5]};
        end else ill = 1;
        if (ill) begin
            y = src;
            return;
        end
        y = '0;
        for (int l = 0; l < 128 / w; l++) begin
            a = (src >> (l * w)) & {64'd0, m};
            r = lane_op(g, c, a, im & m, w, m) & m;
            y = y | ({64'd0, r} << (l * w));
        end
    endfunction

    task automatic send(input logic [31:0] wd, input logic [127:0] src, input string tag);
        exp_t e;
        model(wd, src, e.ill, e.vec);
        e.rd  = wd[4:0];
        e.tag = tag;
        sb_q.push_back(e);
        last_vec = e.vec;
        @(posedge clk); #1;
        in_valid = 1'b1;
        instr    = wd;
        src_vec  = src;
        @(posedge clk); #1;
        in_valid = 1'b0;
        instr    = $urandom;
    endtask

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb_q.size() == 0) begin
                chk(0, "R9 unexpected out_valid", {127'd0, out_valid}, 128'd0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(dst_vec == e.vec, {e.tag, " dst_vec"}, dst_vec, e.vec);
                chk(out_illegal == e.ill, {e.tag, " R8 illegal flag"},
                    {127'd0, out_illegal}, {127'd0, e.ill});
                chk(dst_reg == e.rd, {e.tag, " R9 dst_reg"}, {123'd0, dst_reg}, {123'd0, e.rd});
            end
        end
    end

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_up();
    end

    localparam logic [127:0] PA = 128'h7F80_00FF_0180_FE7F_8000_7FFF_FFFF_0001;
    localparam logic [127:0] PB = 128'h8000_0000_0000_0000_7FFF_FFFF_FFFF_FFFF;
    localparam logic [127:0] PC = 128'h0102_0304_0506_0708_F0F1_F2F3_F4F5_F6F7;

    initial begin : stim
        logic [127:0] rv;
        repeat (3) @(posedge clk);
        #1;
        // R11 reset state
        chk(out_valid == 1'b0, "R11 out_valid in reset", {127'd0, out_valid}, 128'd0);
        chk(out_illegal == 1'b0, "R11 out_illegal in reset", {127'd0, out_illegal}, 128'd0);
        chk(dst_vec == '0, "R11 dst_vec in reset", dst_vec, 128'd0);
        rst_n = 1'b1;

        // R3 add wraps in byte lanes, no carry across lanes (R2)
        send(mk(3'b100, 3'b000, 2'b00, 3'b110, 8'h81, 5'd3), PA, "R3 add b8");
        // R3 subtract with shifted immediate in 16-bit lanes keeps all 16 bits
        send(mk(3'b100, 3'b001, 2'b01, 3'b111, 8'hFF, 5'd7), PA, "R3 sub h16 shift");
        // R3 reverse subtract
        send(mk(3'b100, 3'b011, 2'b10, 3'b110, 8'h10, 5'd9), PC, "R3 subr s32");
        // R4 signed saturating add clamps to max
        send(mk(3'b100, 3'b100, 2'b00, 3'b110, 8'hFF, 5'd1), PA, "R4 sqadd b8 clamp");
        // R4 signed saturating subtract clamps to min
        send(mk(3'b100, 3'b110, 2'b11, 3'b111, 8'h01, 5'd2), PB, "R4 sqsub d64 clamp");
        // R4 unsigned saturating add to all-ones, subtract to zero
        send(mk(3'b100, 3'b101, 2'b01, 3'b111, 8'h80, 5'd4), PA, "R4 uqadd h16");
        send(mk(3'b100, 3'b111, 2'b00, 3'b110, 8'h80, 5'd5), PA, "R4 uqsub b8");
        // R6 min/max
        send(mk(3'b101, 3'b000, 2'b00, 3'b110, 8'hF0, 5'd6), PA, "R6 smax b8");
        send(mk(3'b101, 3'b001, 2'b00, 3'b110, 8'hF0, 5'd6), PA, "R6 umax b8");
        send(mk(3'b101, 3'b010, 2'b11, 3'b110, 8'h80, 5'd6), PB, "R6 smin d64");
        send(mk(3'b101, 3'b011, 2'b01, 3'b110, 8'h80, 5'd6), PA, "R6 umin h16");
        // R7 multiply by negative immediate, 64-bit lanes
        send(mk(3'b110, 3'b000, 2'b11, 3'b110, 8'hFD, 5'd8), PC, "R7 mul d64");
        // R1 bad head byte
        send({8'h24, mk(3'b100, 3'b000, 2'b00, 3'b110, 8'h01, 5'd10)}[31:0] ^ 32'h0100_0000,
             PC, "R1 bad head");
        // R5 rejects
        send(mk(3'b100, 3'b000, 2'b00, 3'b111, 8'h01, 5'd11), PC, "R5 byte shift");
        send(mk(3'b100, 3'b010, 2'b01, 3'b110, 8'h01, 5'd12), PC, "R5 code 010");
        send(mk(3'b100, 3'b000, 2'b01, 3'b010, 8'h01, 5'd13), PC, "R5 bits15:14");
        // R6 / R7 rejects
        send(mk(3'b101, 3'b100, 2'b01, 3'b110, 8'h01, 5'd14), PC, "R6 code 1xx");
        send(mk(3'b101, 3'b000, 2'b01, 3'b111, 8'h01, 5'd15), PC, "R6 bits15:13");
        send(mk(3'b110, 3'b001, 2'b10, 3'b110, 8'h01, 5'd16), PC, "R7 mul code");
        send(mk(3'b111, 3'b000, 2'b10, 3'b110, 8'h01, 5'd17), PC, "R7 bad group");

        // R10 hold while idle
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R10 idle out_valid", {127'd0, out_valid}, 128'd0);
        chk(dst_vec == last_vec, "R10 idle hold dst_vec", dst_vec, last_vec);

        // R2 sweep every width and every legal code
        for (int e = 0; e < 4; e++) begin
            for (int c = 0; c < 8; c++) begin
                if (c == 2) continue;
                rv = {$urandom, $urandom, $urandom, $urandom};
                send(mk(3'b100, 3'(c), 2'(e), (e == 0) ? 3'b110 : 3'b111, 8'($urandom), 5'(c)),
                     rv, "R2 addsub sweep");
            end
            for (int c = 0; c < 4; c++) begin
                rv = {$urandom, $urandom, $urandom, $urandom};
                send(mk(3'b101, 3'(c), 2'(e), 3'b110, 8'($urandom), 5'(c)), rv, "R2 minmax sweep");
            end
            rv = {$urandom, $urandom, $urandom, $urandom};
            send(mk(3'b110, 3'b000, 2'(e), 3'b110, 8'($urandom), 5'(e)), rv, "R2 mul sweep");
        end

        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(sb_q.size() == 0, "R9 responses drained", 128'(sb_q.size()), 128'd0);
        finish_up();
    end

endmodule